// File: doc/BRIEF.md
# Serial DAC Code Loader

This block is the digital front end of a serially programmed 8-bit digital-to-analogue converter. A host writes 16-bit words over three wires: an active-low frame line that also enables the device, a serial clock, and a serial data line. Each word carries a two-bit command and fourteen data bits, most significant bit first. When a load command ends with a properly counted frame, the eight top data bits become the new converter code.

All three wires are asynchronous to the fast system clock. Each one passes through a two-flop synchroniser, and edges are found from the synchronised samples, so the serial clock must run at no more than a quarter of the system clock rate. The output side is a plain parallel code with a one-cycle update strobe. The strobe is a valid with no ready: the consumer cannot apply back-pressure and must accept the code in the strobe cycle. The code itself stays held until the next load.

Top module: `serdac_frontend`

## Requirements
- R1: After reset the code output is 0, the update strobe is low, and data is taken on the falling serial clock edge.
- R2: Serial data is shifted most significant bit first. Frame bit 15 is the first bit sent. Bits 15:14 are the command, and command 00 is a load. A load frame with exactly 16 active edges, followed by the frame line going high, writes frame bits 13:6 to the code output.
- R3: Frame bits 5:0 are received and discarded, so changing them never changes the code.
- R4: The update strobe is high for exactly one system clock on each load and low at all other times. The code output changes only in a strobe cycle.
- R5: A frame that ends with fewer than 16 active edges is dropped. The code and edge selection are unchanged, no strobe is raised, and the next frame counts from zero.
- R6: A frame that ends with more than 16 active edges is dropped in the same way.
- R7: Commands 01 and 10 are reserved. They change neither the code nor the active edge, and they raise no strobe.
- R8: Command 11 switches all later frames to the rising serial clock edge. It does not change the code and raises no strobe. The setting holds until reset.
- R9: Serial clock edges and data seen while the frame line is high are ignored. Each falling edge of the frame line restarts the edge count.
- R10: The strobe and the new code appear after the third system clock rising edge, counting from the first edge that samples the frame line high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, asynchronous, at most clk/4 |
| sync_n_i | input | 1 | Active-low frame and enable line |
| sdin_i | input | 1 | Serial data, most significant bit first |
| dac_code_o | output | 8 | Held converter code |
| update_o | output | 1 | One-cycle strobe when dac_code_o is loaded |

## Verification
The bench sends frames with 15, 16 and 17 edges. A counter that checks "at least 16" or that wraps would load the 15- or 17-edge frame and change the code. It also sends frames whose data differs between the falling and the rising half of each bit, which shows at the code output which edge is active. This exposes a design that lets a reserved command touch the edge select, or one that never switches edges. Other cases toggle the serial clock with the frame line high and flip only the discarded low bits, so a design that counts idle edges, or that takes the wrong slice of the frame, loads a wrong value. The strobe latency is checked at the exact cycle, which catches a missing or extra pipeline stage.

// File: rtl/serdac_pkg.sv
package serdac_pkg;
  localparam int CMD_W = 2;

  typedef enum logic [CMD_W-1:0] {
    CMD_LOAD  = 2'b00,
    CMD_RSV_A = 2'b01,
    CMD_RSV_B = 2'b10,
    CMD_RISE  = 2'b11
  } cmd_e;
endpackage

// File: rtl/serdac_sync.sv
module serdac_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/serdac_edge.sv
module serdac_edge #(
  parameter int W = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
endmodule

// File: rtl/serdac_shifter.sv
module serdac_shifter #(
  parameter int FRAME_W = 16,
  parameter int HEAD_W  = 10,
  parameter int CNT_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              frame_end,
  input  logic              shift_en,
  input  logic              sdin,
  output logic [HEAD_W-1:0] head,
  output logic [CNT_W-1:0]  bit_cnt
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

  logic [FRAME_W-1:0] sr_q;
  logic [CNT_W-1:0]   cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (frame_start || frame_end) begin
      cnt_q <= '0;
    end else if (shift_en) begin
      if (cnt_q < FULL)  sr_q  <= {sr_q[FRAME_W-2:0], sdin};
      if (cnt_q <= FULL) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign head    = sr_q[FRAME_W-1 -: HEAD_W];
  assign bit_cnt = cnt_q;
endmodule

// File: rtl/serdac_ctrl.sv
module serdac_ctrl
  import serdac_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int CODE_W  = 8,
  parameter int CNT_W   = 5,
  localparam int HEAD_W = CMD_W + CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_end,
  input  logic [HEAD_W-1:0] head,
  input  logic [CNT_W-1:0]  bit_cnt,
  output logic [CODE_W-1:0] dac_code,
  output logic              update,
  output logic              edge_sel
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

  cmd_e cmd;
  logic complete;

  assign cmd      = cmd_e'(head[HEAD_W-1 -: CMD_W]);
  assign complete = frame_end && (bit_cnt == FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_code <= '0;
      update   <= 1'b0;
      edge_sel <= 1'b0;
    end else begin
      update <= 1'b0;
      if (complete) begin
        unique case (cmd)
          CMD_LOAD: begin
            dac_code <= head[CODE_W-1:0];
            update   <= 1'b1;
          end
          CMD_RISE:  edge_sel <= 1'b1;
          default:   ;
        endcase
      end
    end
  end
endmodule

// File: rtl/serdac_frontend.sv
module serdac_frontend #(
  parameter int FRAME_W     = 16,
  parameter int CODE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              sync_n_i,
  input  logic              sdin_i,
  output logic [CODE_W-1:0] dac_code_o,
  output logic              update_o
);
  localparam int HEAD_W = serdac_pkg::CMD_W + CODE_W;
  localparam int CNT_W  = $clog2(FRAME_W + 2);

  logic [2:0] raw_in, syn;
  logic [1:0] rise_v, fall_v;
  logic       s_sclk, s_sync_n, s_sdin;
  logic       sclk_rise, sclk_fall, sync_rise, sync_fall;
  logic       shift_en, edge_sel;
  logic [HEAD_W-1:0] head;
  logic [CNT_W-1:0]  bit_cnt;

  assign raw_in = {sclk_i, sync_n_i, sdin_i};

  serdac_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn)
  );

  assign s_sclk   = syn[2];
  assign s_sync_n = syn[1];
  assign s_sdin   = syn[0];

  serdac_edge #(.W(2), .RST_VAL(2'b01)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl({s_sclk, s_sync_n}),
    .rise(rise_v), .fall(fall_v)
  );

  assign sclk_rise = rise_v[1];
  assign sclk_fall = fall_v[1];
  assign sync_rise = rise_v[0];
  assign sync_fall = fall_v[0];

  assign shift_en = !s_sync_n && (edge_sel ? sclk_rise : sclk_fall);

  serdac_shifter #(.FRAME_W(FRAME_W), .HEAD_W(HEAD_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .frame_start(sync_fall), .frame_end(sync_rise),
    .shift_en(shift_en), .sdin(s_sdin), .head(head), .bit_cnt(bit_cnt)
  );

  serdac_ctrl #(.FRAME_W(FRAME_W), .CODE_W(CODE_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .frame_end(sync_rise), .head(head),
    .bit_cnt(bit_cnt), .dac_code(dac_code_o), .update(update_o),
    .edge_sel(edge_sel)
  );
endmodule

// File: rtl/serdac_checker.sv
module serdac_checker #(
  parameter int CODE_W = 8,
  parameter int CNT_W  = 5,
  parameter int FRAME_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] dac_code_o,
  input logic              update_o,
  input logic              sync_rise,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic              edge_sel
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (dac_code_o == '0 && !update_o));

  assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    update_o |=> !update_o);

  assert_code_only_on_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_code_o) |-> update_o);

  assert_load_needs_full_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    update_o |-> ($past(bit_cnt) == CNT_W'(FRAME_W) && $past(sync_rise)));

  assert_count_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(FRAME_W + 1));

  assert_edge_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(edge_sel) |-> edge_sel);
endmodule

bind serdac_frontend serdac_checker #(.CODE_W(CODE_W), .CNT_W(CNT_W), .FRAME_W(FRAME_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dac_code_o(dac_code_o), .update_o(update_o),
  .sync_rise(sync_rise), .bit_cnt(bit_cnt), .edge_sel(edge_sel)
);

// File: tb/tb_serdac_frontend.sv
`timescale 1ns/1ps
module tb_serdac_frontend;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1, sync_n = 1'b1, sdin = 1'b0;
  logic [7:0] dac_code_o;
  logic update_o;

  int checks = 0, fails = 0, strobes = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  serdac_frontend dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sync_n_i(sync_n), .sdin_i(sdin),
    .dac_code_o(dac_code_o), .update_o(update_o)
  );

  // behavioural reference: inputs seen two clocks late, edges from a sample history
  logic [2:0] hist[$];
  int m_cnt;
  logic [15:0] m_sr;
  logic m_rise_mode;
  logic [7:0] m_code;
  logic m_upd;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = {3'b010, 3'b010, 3'b010};
      m_cnt = 0; m_sr = '0; m_rise_mode = 0; m_code = '0; m_upd = 0;
    end else begin
      logic [2:0] cur, old;
      hist.push_back({sclk, sync_n, sdin});
      cur = hist[hist.size()-3];
      old = hist[hist.size()-4];
      m_upd = 0;
      if (old[1] && !cur[1]) m_cnt = 0;
      else if (!old[1] && cur[1]) begin
        if (m_cnt == 16) begin
          if (m_sr[15:14] == 2'b00) begin m_code = m_sr[13:6]; m_upd = 1; end
          else if (m_sr[15:14] == 2'b11) m_rise_mode = 1;
        end
        m_cnt = 0;
      end else if (!cur[1] && (m_rise_mode ? (cur[2] && !old[2]) : (!cur[2] && old[2]))) begin
        if (m_cnt < 16) m_sr = {m_sr[14:0], cur[0]};
        if (m_cnt < 17) m_cnt++;
      end
      if (hist.size() > 8) void'(hist.pop_front());
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (dac_code_o !== m_code || update_o !== m_upd) begin
        fails++;
        $display("FAIL R2/R4 model compare: code=%h upd=%b expected code=%h upd=%b",
                 dac_code_o, update_o, m_code, m_upd);
      end
      if (update_o) strobes++;
    end
  end

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // fw: bit driven for the falling half, rw: bit driven for the rising half
  task automatic send(input logic [15:0] fw, input logic [15:0] rw, input int n,
                      input bit chk_lat);
    logic u2, u3;
    @(negedge clk); sync_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sdin = fw[15 - (i % 16)];
      repeat (2) @(negedge clk); sclk = 1'b0;
      repeat (2) @(negedge clk); sdin = rw[15 - (i % 16)];
      repeat (2) @(negedge clk); sclk = 1'b1;
      repeat (2) @(negedge clk);
    end
    repeat (2) @(negedge clk);
    sync_n = 1'b1;
    @(posedge clk); @(posedge clk); #1 u2 = update_o;
    @(posedge clk); #1 u3 = update_o;
    if (chk_lat) begin
      check("R10 strobe not before third edge", {15'b0, u2}, 16'h0);
      check("R10 strobe at third edge", {15'b0, u3}, 16'h1);
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic frame(input logic [15:0] w, input int n, input bit chk_lat);
    send(w, w, n, chk_lat);
  endtask

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    check("R1 reset code", {8'h0, dac_code_o}, 16'h0);
    check("R1 reset strobe", {15'b0, update_o}, 16'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle after reset", {7'b0, update_o, dac_code_o}, 16'h0);

    s0 = strobes;
    frame({2'b00, 8'h3C, 6'b000000}, 16, 1);
    check("R2 load 3C", {8'h0, dac_code_o}, 16'h003C);
    check("R4 one strobe per load", 16'(strobes - s0), 16'h1);

    frame({2'b00, 8'hA5, 6'b111111}, 16, 0);
    check("R3 low bits set", {8'h0, dac_code_o}, 16'h00A5);
    frame({2'b00, 8'hA5, 6'b010101}, 16, 0);
    check("R3 low bits changed", {8'h0, dac_code_o}, 16'h00A5);

    s0 = strobes;
    frame({2'b00, 8'h11, 6'b0}, 15, 0);
    check("R5 short frame dropped", {8'h0, dac_code_o}, 16'h00A5);
    frame({2'b00, 8'h22, 6'b0}, 17, 0);
    check("R6 long frame dropped", {8'h0, dac_code_o}, 16'h00A5);
    check("R5 R6 no strobe", 16'(strobes - s0), 16'h0);

    frame({2'b01, 8'h33, 6'b0}, 16, 0);
    frame({2'b10, 8'h44, 6'b0}, 16, 0);
    check("R7 reserved keeps code", {8'h0, dac_code_o}, 16'h00A5);
    send({2'b00, 8'h5A, 6'b0}, {2'b00, 8'hC3, 6'b0}, 16, 0);
    check("R7 still falling edge", {8'h0, dac_code_o}, 16'h005A);

    s0 = strobes;
    frame({2'b11, 8'h77, 6'b0}, 16, 0);
    check("R8 edge command keeps code", {8'h0, dac_code_o}, 16'h005A);
    check("R8 edge command no strobe", 16'(strobes - s0), 16'h0);
    send({2'b00, 8'h12, 6'b0}, {2'b00, 8'h81, 6'b0}, 16, 1);
    check("R8 rising edge active", {8'h0, dac_code_o}, 16'h0081);

    for (int k = 0; k < 10; k++) begin
      sdin = k[0];
      repeat (4) @(negedge clk); sclk = 1'b0;
      repeat (4) @(negedge clk); sclk = 1'b1;
    end
    frame({2'b00, 8'h9E, 6'b0}, 16, 0);
    check("R9 idle edges ignored", {8'h0, dac_code_o}, 16'h009E);
    frame({2'b00, 8'h01, 6'b0}, 9, 0);
    frame({2'b00, 8'hE7, 6'b0}, 16, 0);
    check("R5 R9 count restarts", {8'h0, dac_code_o}, 16'h00E7);

    repeat (10) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule